// File: doc/BRIEF.md
# Pending Tag-Update Forwarding Queue

This block sits between the check stage and the commit stage of a pipeline that keeps a small state tag for every data word. When the check stage decides a new tag value for an address, that value cannot be written to the tag cache until the instruction commits. Until then the update waits here, in program order. Any later tag lookup in the check stage first asks this queue: if a pending update targets the same address, the queued value replaces the stale tag read from the cache.

Addresses are fully resolved before an update is queued, so a dependence is an exact address compare. Where several pending updates target one address, the youngest one is forwarded. At commit the oldest entries are presented on a write port toward the tag cache and retired in order. On an exception the pipeline flushes, and the queue keeps only the oldest entries that belong to surviving instructions.

The push side follows valid/ready rules. `push_valid` must be a thermometer starting at lane 0, with lane 0 the oldest. The whole group is taken on a cycle where `push_ready` is high and `flush` is low; otherwise nothing is taken and the check stage must hold. `push_ready` is a level that depends only on occupancy, so it never depends on `push_valid`. The commit side uses `wr_valid` and `wr_ready` per lane. `wr_ready` must also be a thermometer from lane 0. A lane retires when both of its bits are high.

Top module: `sfq`

## Requirements
- R1: After reset the queue is empty. `wr_valid` is 0, `lookup_hit` is 0 and `push_ready` is 1.
- R2: On an accepted cycle, each valid push lane becomes one entry, and lane 0 is older than lane 1 and so on. When `push_ready` is low, pushes are ignored and nothing is queued.
- R3: `wr_valid[i]` is high exactly when at least i+1 entries are held. `wr_addr`/`wr_state` lane i carry the i-th oldest entry, with lane i in bits [i*W +: W]. Each lane where `wr_valid` and `wr_ready` are both high removes one entry at the clock edge.
- R4: Entries leave through the commit port in the same order in which they were pushed.
- R5: `lookup_hit` is high only when a held entry's address equals `lookup_addr` in every bit. An entry pushed in the same cycle as the lookup is not seen until the following cycle.
- R6: When several held entries match the lookup address, `lookup_state` comes from the youngest of them.
- R7: An entry that is retiring still forwards during its retiring cycle. It no longer forwards from the next cycle on.
- R8: On a `flush`, only the `flush_keep` oldest entries are kept and the rest are discarded. Pushes offered in that cycle are also dropped.
- R9: Retirements in a flush cycle come out of the kept entries. The entry count afterwards is the kept count minus the number retired.
- R10: The queue never holds more than DEPTH entries. `push_ready` is high exactly when at least PUSH_W slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | PUSH_W | Thermometer of pushed lanes, lane 0 oldest |
| push_addr | input | PUSH_W*ADDR_W | Per-lane tag address |
| push_state | input | PUSH_W*STATE_W | Per-lane new tag state |
| push_ready | output | 1 | Room for a full push group |
| lookup_addr | input | ADDR_W | Address looked up by the check stage |
| lookup_hit | output | 1 | A pending entry matches |
| lookup_state | output | STATE_W | State from the youngest matching entry |
| wr_valid | output | POP_W | Lane i holds the i-th oldest entry |
| wr_addr | output | POP_W*ADDR_W | Tag-cache write address per lane |
| wr_state | output | POP_W*STATE_W | Tag-cache write state per lane |
| wr_ready | input | POP_W | Commit retires lane i (thermometer) |
| flush | input | 1 | Discard younger entries |
| flush_keep | input | $clog2(DEPTH+1) | Number of oldest entries kept on flush |

## Verification
Several properties are checked on every cycle. Occupancy never exceeds capacity, and `wr_valid` stays a thermometer. A hit can only occur while something is held. A stalled push side implies a full commit window. A flush never leaves more entries than it asked to keep. After a single retirement, the second-oldest entry moves to lane 0. Other behaviours need the bench's scenarios: youngest-match forwarding for back-to-back updates to one tag, the hidden same-cycle push, forwarding from a retiring entry, pushes dropped while full or flushing, and the full commit order.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  // population count of a lane mask
  function automatic int unsigned lane_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // true when the set bits form a run starting at bit 0
  function automatic logic is_thermo(input logic [31:0] v);
    return (v & (v + 32'd1)) == 32'd0;
  endfunction
endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
  parameter int DEPTH   = 8,
  parameter int PUSH_W  = 4,
  parameter int ADDR_W  = 16,
  parameter int STATE_W = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic [PTR_W-1:0]            wr_base,
  input  logic [CNT_W-1:0]            wr_n,
  input  logic [PUSH_W*ADDR_W-1:0]    in_addr,
  input  logic [PUSH_W*STATE_W-1:0]   in_state,
  output logic [DEPTH*ADDR_W-1:0]     ent_addr,
  output logic [DEPTH*STATE_W-1:0]    ent_state
);
  logic [ADDR_W-1:0]  mem_a [DEPTH];
  logic [STATE_W-1:0] mem_s [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_W; k++) begin
      if (CNT_W'(k) < wr_n) begin
        mem_a[wr_base + PTR_W'(k)] <= in_addr[k*ADDR_W +: ADDR_W];
        mem_s[wr_base + PTR_W'(k)] <= in_state[k*STATE_W +: STATE_W];
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_flat
    assign ent_addr[e*ADDR_W +: ADDR_W]    = mem_a[e];
    assign ent_state[e*STATE_W +: STATE_W] = mem_s[e];
  end
endmodule

// File: rtl/sfq_match.sv
module sfq_match #(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int STATE_W = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*ADDR_W-1:0]  ent_addr,
  input  logic [DEPTH*STATE_W-1:0] ent_state,
  input  logic [PTR_W-1:0]         head,
  input  logic [CNT_W-1:0]         count,
  input  logic [ADDR_W-1:0]        key,
  output logic                     hit,
  output logic [STATE_W-1:0]       state
);
  // scan oldest to youngest so the youngest match is the last one assigned
  always_comb begin
    hit   = 1'b0;
    state = '0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [PTR_W-1:0] idx;
      idx = head + PTR_W'(a);
      if (CNT_W'(a) < count && ent_addr[idx*ADDR_W +: ADDR_W] == key) begin
        hit   = 1'b1;
        state = ent_state[idx*STATE_W +: STATE_W];
      end
    end
  end
endmodule

// File: rtl/sfq.sv
module sfq #(
  parameter int DEPTH   = 8,
  parameter int PUSH_W  = 4,
  parameter int POP_W   = 4,
  parameter int ADDR_W  = 16,
  parameter int STATE_W = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PUSH_W-1:0]         push_valid,
  input  logic [PUSH_W*ADDR_W-1:0]  push_addr,
  input  logic [PUSH_W*STATE_W-1:0] push_state,
  output logic                      push_ready,
  input  logic [ADDR_W-1:0]         lookup_addr,
  output logic                      lookup_hit,
  output logic [STATE_W-1:0]        lookup_state,
  output logic [POP_W-1:0]          wr_valid,
  output logic [POP_W*ADDR_W-1:0]   wr_addr,
  output logic [POP_W*STATE_W-1:0]  wr_state,
  input  logic [POP_W-1:0]          wr_ready,
  input  logic                      flush,
  input  logic [CNT_W-1:0]          flush_keep
);
  import sfq_pkg::*;

  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] push_n, pop_n, keep_eff, count_nx;
  logic [PTR_W-1:0] tail;
  logic [DEPTH*ADDR_W-1:0]  ent_addr;
  logic [DEPTH*STATE_W-1:0] ent_state;

  assign push_ready = count <= CNT_W'(DEPTH - PUSH_W);
  assign tail       = head + PTR_W'(count);
  assign push_n     = (push_ready && !flush) ? CNT_W'(lane_ones(32'(push_valid))) : '0;
  assign pop_n      = CNT_W'(lane_ones(32'(wr_ready & wr_valid)));
  assign keep_eff   = (flush_keep < count) ? flush_keep : count;

  always_comb begin
    if (flush)
      count_nx = (pop_n > keep_eff) ? '0 : keep_eff - pop_n;
    else
      count_nx = count - pop_n + push_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      head  <= head + PTR_W'(pop_n);
      count <= count_nx;
    end
  end

  sfq_store #(.DEPTH(DEPTH), .PUSH_W(PUSH_W), .ADDR_W(ADDR_W), .STATE_W(STATE_W)) u_store (
    .clk(clk), .wr_base(tail), .wr_n(push_n),
    .in_addr(push_addr), .in_state(push_state),
    .ent_addr(ent_addr), .ent_state(ent_state)
  );

  sfq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .STATE_W(STATE_W)) u_match (
    .ent_addr(ent_addr), .ent_state(ent_state), .head(head), .count(count),
    .key(lookup_addr), .hit(lookup_hit), .state(lookup_state)
  );

  for (genvar i = 0; i < POP_W; i++) begin : g_commit
    logic [PTR_W-1:0] rd_idx;
    assign rd_idx = head + PTR_W'(i);
    assign wr_valid[i] = count > CNT_W'(i);
    assign wr_addr[i*ADDR_W +: ADDR_W]    = ent_addr[rd_idx*ADDR_W +: ADDR_W];
    assign wr_state[i*STATE_W +: STATE_W] = ent_state[rd_idx*STATE_W +: STATE_W];
  end
endmodule

// File: rtl/sfq_chk.sv
module sfq_chk #(
  parameter int DEPTH   = 8,
  parameter int PUSH_W  = 4,
  parameter int POP_W   = 4,
  parameter int ADDR_W  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic [CNT_W-1:0]        flush_keep,
  input logic [POP_W-1:0]        wr_valid,
  input logic [POP_W-1:0]        wr_ready,
  input logic [POP_W*ADDR_W-1:0] wr_addr,
  input logic                    lookup_hit,
  input logic                    push_ready,
  input logic [CNT_W-1:0]        count
);
  import sfq_pkg::*;

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r10_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && (DEPTH - PUSH_W + 1 >= POP_W)) |-> (&wr_valid));

  a_r3_valid_thermo: assert property (@(posedge clk) disable iff (!rst_n)
    is_thermo(32'(wr_valid)));

  a_r5_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |-> wr_valid[0]);

  a_r8_flush_bound: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count <= $past(flush_keep));

  if (POP_W >= 2) begin : g_shift
    a_r4_commit_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && wr_ready[0] && !wr_ready[1] && wr_valid[1])
      |=> wr_addr[ADDR_W-1:0] == $past(wr_addr[2*ADDR_W-1:ADDR_W]));
  end
endmodule

bind sfq sfq_chk #(.DEPTH(DEPTH), .PUSH_W(PUSH_W), .POP_W(POP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .flush_keep(flush_keep),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .lookup_hit(lookup_hit), .push_ready(push_ready), .count(count)
);

// File: tb/sfq_test.sv
module sfq_test;
  localparam int DEPTH = 8, PUSH_W = 4, POP_W = 4, ADDR_W = 16, STATE_W = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NV = 8;
  // {pv4, a0 8, s0 4, a1 8, s1 4, pop4, look8, hit1, st4, valid4, lane0addr8}
  localparam logic [56:0] VEC [NV] = '{
    {4'b0011, 8'h10, 4'h1, 8'h20, 4'h2, 4'b0000, 8'h10, 1'b0, 4'h0, 4'b0000, 8'h00},
    {4'b0011, 8'h10, 4'h5, 8'h10, 4'h6, 4'b0000, 8'h10, 1'b1, 4'h1, 4'b0011, 8'h10},
    {4'b0000, 8'h00, 4'h0, 8'h00, 4'h0, 4'b0001, 8'h10, 1'b1, 4'h6, 4'b1111, 8'h10},
    {4'b0001, 8'h30, 4'h7, 8'h00, 4'h0, 4'b0011, 8'h20, 1'b1, 4'h2, 4'b0111, 8'h20},
    {4'b0000, 8'h00, 4'h0, 8'h00, 4'h0, 4'b0001, 8'h10, 1'b1, 4'h6, 4'b0011, 8'h10},
    {4'b0011, 8'h40, 4'h3, 8'h41, 4'h4, 4'b0000, 8'h10, 1'b0, 4'h0, 4'b0001, 8'h30},
    {4'b0000, 8'h00, 4'h0, 8'h00, 4'h0, 4'b0111, 8'h41, 1'b1, 4'h4, 4'b0111, 8'h30},
    {4'b0000, 8'h00, 4'h0, 8'h00, 4'h0, 4'b0000, 8'h41, 1'b0, 4'h0, 4'b0000, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PUSH_W-1:0]         push_valid = '0;
  logic [PUSH_W*ADDR_W-1:0]  push_addr = '0;
  logic [PUSH_W*STATE_W-1:0] push_state = '0;
  logic                      push_ready;
  logic [ADDR_W-1:0]         lookup_addr = '0;
  logic                      lookup_hit;
  logic [STATE_W-1:0]        lookup_state;
  logic [POP_W-1:0]          wr_valid;
  logic [POP_W*ADDR_W-1:0]   wr_addr;
  logic [POP_W*STATE_W-1:0]  wr_state;
  logic [POP_W-1:0]          wr_ready = '0;
  logic                      flush = 1'b0;
  logic [CNT_W-1:0]          flush_keep = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sfq uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    push_valid = '0; wr_ready = '0; flush = 1'b0; flush_keep = '0;
  endtask

  task automatic push4(input logic [7:0] base, input logic [3:0] st);
    for (int k = 0; k < PUSH_W; k++) begin
      push_addr[k*ADDR_W +: ADDR_W]    = {8'h00, base + 8'(k)};
      push_state[k*STATE_W +: STATE_W] = st;
    end
    push_valid = '1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready", 32'(push_ready), 32'd1);
    chk("R1 valid", 32'(wr_valid), 32'd0);
    chk("R1 hit", 32'(lookup_hit), 32'd0);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [56:0] t;
      t = VEC[v];
      push_valid  = t[56:53];
      push_addr   = {32'h0, 8'h00, t[40:33], 8'h00, t[52:45]};
      push_state  = {8'h0, t[32:29], t[44:41]};
      wr_ready    = t[28:25];
      lookup_addr = {8'h00, t[24:17]};
      #1;
      chk("R5/R6/R7 hit", 32'(lookup_hit), 32'(t[16]));
      if (t[16]) chk("R6 youngest state", 32'(lookup_state), 32'(t[15:12]));
      chk("R3 occupancy", 32'(wr_valid), 32'(t[11:8]));
      if (t[8]) chk("R4 commit order", 32'(wr_addr[15:0]), {24'h0, t[7:0]});
      tick();
    end
    idle();

    // fill: two full groups
    push4(8'h50, 4'h1); tick();
    chk("R10 ready at four free", 32'(push_ready), 32'd1);
    push4(8'h50, 4'h2); tick();
    push4(8'h99, 4'hF); lookup_addr = 16'h0050;
    #1;
    chk("R10 full stall", 32'(push_ready), 32'd0);
    chk("R3 full window", 32'(wr_valid), 32'hF);
    chk("R6 youngest on full", 32'(lookup_state), 32'h2);
    tick();
    push_valid = '0;
    lookup_addr = 16'h0099; flush = 1'b1; flush_keep = CNT_W'(3); wr_ready = 4'b0001;
    #1;
    chk("R2 ignored while full", 32'(lookup_hit), 32'd0);
    tick();
    push4(8'h60, 4'h9); flush = 1'b1; flush_keep = CNT_W'(2); wr_ready = '0;
    lookup_addr = 16'h0050;
    #1;
    chk("R9 kept minus retired", 32'(wr_valid), 32'h3);
    chk("R9 lane0 after flush", 32'(wr_addr[15:0]), 32'h51);
    chk("R8 younger dropped", 32'(lookup_hit), 32'd0);
    tick();
    idle(); lookup_addr = 16'h0060;
    #1;
    chk("R8 push dropped on flush", 32'(lookup_hit), 32'd0);
    chk("R8 count kept", 32'(wr_valid), 32'h3);
    chk("R4 lane1 order", 32'(wr_addr[31:16]), 32'h52);
    wr_ready = 4'b0011;
    tick();
    idle();
    #1;
    chk("R3 drained", 32'(wr_valid), 32'd0);
    chk("R10 ready when empty", 32'(push_ready), 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule